// File: doc/BRIEF.md
# Flash Access Control Register

This block is the main control register of an embedded flash controller. It holds the flash wait-state count, the prefetch enable, the enable and flush controls of the instruction and data caches, the debugger enable, and two power-down selections: one for run mode and one for sleep mode. Software reaches it over a simple single-cycle bus. Each write carries four byte-lane enables, so word, half-word and byte writes all complete with no wait state. Reads return the register contents combinationally, in the same cycle as the read strobe.

Some fields have conditions on their writes. The run-mode power-down bit is guarded by a separate key register. Software must write two fixed 32-bit key values to that register in succession to open the guard. One write to the control register's second byte lane then uses up the unlock. A wrong key relocks the guard until reset. The data-cache flush bit changes only while the data cache is disabled.

From the power-down selections and the current CPU mode, the block drives a flash power-down request. The request is held low while the program/erase logic is busy. While run-mode power-down is selected, flash read requests are not forwarded and an access error is reported instead.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the control register reads 0x0000_0600: the instruction cache enable (bit 9) and the data cache enable (bit 10) are set and all other bits are clear. The flash power-down output is 0 and the key guard is locked.
- R2: Each byte-lane enable bus_be[i] updates only bits 8i+7..8i of the control register. The implemented fields are wait states (bits 3:0), prefetch (bit 8), instruction cache enable (bit 9), data cache enable (bit 10), instruction cache flush (bit 11), data cache flush (bit 12), run power-down (bit 13), sleep power-down (bit 14) and debugger enable (bit 18). All other bits always read 0.
- R3: A read of the control offset (0x0) returns the register in the same cycle the read strobe is asserted. bus_rdata is 0 on a read of the key offset (0x4) and whenever no read is in progress.
- R4: A write to the data cache flush bit (bit 12) takes effect only if the data cache enable (bit 10) was 0 before that write. Otherwise bit 12 keeps its value.
- R5: Writes to the run power-down bit (bit 13) are ignored unless the key guard is open. The guard opens after two consecutive full-word writes to the key offset: first KEY_A (default 0x0415_2637), then KEY_B (default 0xFAFB_FCFD).
- R6: Any control write with bus_be[1] set while the guard is open applies bit 13 and closes the guard again. A new key sequence is then needed before bit 13 can change again.
- R7: A key write that has the wrong value, is not a full word (bus_be not 4'hF), or arrives while the guard is already open locks the guard permanently until reset.
- R8: When pe_busy is 0, flash_pd equals bit 14 if sleep_mode is 1, and bit 13 if sleep_mode is 0.
- R9: flash_pd is 0 in every cycle in which pe_busy is 1. A pending request reappears in the first cycle that pe_busy is 0.
- R10: While bit 13 is 1, rd_req is not forwarded (rd_fwd=0) and acc_err equals rd_req. While bit 13 is 0, rd_fwd equals rd_req and acc_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset (0x0 control, 0x4 key) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| sleep_mode | input | 1 | 1 = CPU in sleep, 0 = run |
| pe_busy | input | 1 | Program/erase in progress |
| rd_req | input | 1 | Flash read request from fetch/load path |
| flash_pd | output | 1 | Flash power-down request |
| rd_fwd | output | 1 | Read request forwarded to the array |
| acc_err | output | 1 | Read attempted while run power-down is set |
| wait_states | output | 4 | Wait-state count |
| prefetch_en | output | 1 | Prefetch enable |
| icache_en | output | 1 | Instruction cache enable |
| dcache_en | output | 1 | Data cache enable |
| icache_rst | output | 1 | Instruction cache flush |
| dcache_rst | output | 1 | Data cache flush |
| dbg_en | output | 1 | Debugger enable |

## Verification
The bench sweeps all sixteen byte-enable combinations against several data patterns. A design that merged lanes wrongly or let reserved bits through would show stray bits on readback. It also steps through the data-cache flush guard with the cache on and with the cache off. A design that judged the guard by the newly written enable instead of the old one would change the flush bit on the write that disables the cache. The key sequence is tested when it succeeds, when the unlock is used up, after a wrong key and after a half-word key. A leaky guard would let bit 13 change in any of those cases. Finally, all four combinations of mode and power-down selection are run with busy toggling. A design that registered the busy mask would drive power-down for one cycle during a program or erase.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    // Implemented control fields, most significant first
    typedef struct packed {
        logic       dbg_on;
        logic       sleep_off;
        logic       run_off;
        logic       dc_flush;
        logic       ic_flush;
        logic       dc_on;
        logic       ic_on;
        logic       pf_on;
        logic [3:0] wait_st;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2,
        KEY_DEAD = 2'd3
    } key_state_t;

    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;

    localparam int POS_PF    = 8;
    localparam int POS_IC    = 9;
    localparam int POS_DC    = 10;
    localparam int POS_ICF   = 11;
    localparam int POS_DCF   = 12;
    localparam int POS_RUN   = 13;
    localparam int POS_SLEEP = 14;
    localparam int POS_DBG   = 18;

    localparam logic [WORD_W-1:0] FIELD_MASK = 32'h0004_7F0F;
    localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0600;

    function automatic logic [WORD_W-1:0] pack_fields(input ctl_fields_t f);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[3:0]       = f.wait_st;
        w[POS_PF]    = f.pf_on;
        w[POS_IC]    = f.ic_on;
        w[POS_DC]    = f.dc_on;
        w[POS_ICF]   = f.ic_flush;
        w[POS_DCF]   = f.dc_flush;
        w[POS_RUN]   = f.run_off;
        w[POS_SLEEP] = f.sleep_off;
        w[POS_DBG]   = f.dbg_on;
        return w;
    endfunction

    function automatic ctl_fields_t unpack_fields(input logic [WORD_W-1:0] w);
        ctl_fields_t f;
        f.wait_st   = w[3:0];
        f.pf_on     = w[POS_PF];
        f.ic_on     = w[POS_IC];
        f.dc_on     = w[POS_DC];
        f.ic_flush  = w[POS_ICF];
        f.dc_flush  = w[POS_DCF];
        f.run_off   = w[POS_RUN];
        f.sleep_off = w[POS_SLEEP];
        f.dbg_on    = w[POS_DBG];
        return f;
    endfunction

endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate
    import flash_ctl_pkg::*;
#(
    parameter logic [31:0] KEY_A = 32'h0415_2637,
    parameter logic [31:0] KEY_B = 32'hFAFB_FCFD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [3:0]  key_be,
    input  logic [31:0] key_data,
    input  logic        consume,
    output logic        run_wr_ok
);

    key_state_t state_q, state_d;
    logic       full_word;

    assign full_word = (key_be == 4'hF);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (key_wr) state_d = (full_word && key_data == KEY_A) ? KEY_HALF : KEY_DEAD;
            KEY_HALF: if (key_wr) state_d = (full_word && key_data == KEY_B) ? KEY_OPEN : KEY_DEAD;
            KEY_OPEN: begin
                if (key_wr)       state_d = KEY_DEAD;
                else if (consume) state_d = KEY_IDLE;
            end
            default:  state_d = KEY_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign run_wr_ok = (state_q == KEY_OPEN);

    // R7: a locked-out guard never reopens before reset
    a_r7_dead_stays: assert property (@(posedge clk) disable iff (rst)
        (state_q == KEY_DEAD) |=> (state_q == KEY_DEAD));

    // R6: an open guard closes after the consuming write
    a_r6_unlock_used: assert property (@(posedge clk) disable iff (rst)
        (run_wr_ok && consume && !key_wr) |=> !run_wr_ok);

    // R5: the guard opens only from the half-unlocked state
    a_r5_open_path: assert property (@(posedge clk) disable iff (rst)
        (state_q != KEY_HALF && state_q != KEY_OPEN) |=> (state_q != KEY_OPEN));

endmodule

// File: rtl/flash_ctl_fields.sv
module flash_ctl_fields
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [LANES-1:0]  ctl_be,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              run_wr_ok,
    output ctl_fields_t       fields,
    output logic [WORD_W-1:0] ctl_word
);

    ctl_fields_t       cur_q, nxt;
    logic [WORD_W-1:0] merged;

    assign ctl_word = pack_fields(cur_q);
    assign fields   = cur_q;

    // per-lane merge of write data over the current word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = ctl_be[g] ? ctl_wdata[8*g +: 8] : ctl_word[8*g +: 8];
    end

    always_comb begin
        nxt = unpack_fields(merged & FIELD_MASK);
        if (cur_q.dc_on) nxt.dc_flush = cur_q.dc_flush;
        if (!run_wr_ok)  nxt.run_off  = cur_q.run_off;
    end

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= unpack_fields(RESET_WORD);
        else if (ctl_wr) cur_q <= nxt;
    end

    // R4: flush bit frozen while the data cache is on
    a_r4_dcflush_guard: assert property (@(posedge clk) disable iff (rst)
        cur_q.dc_on |=> $stable(cur_q.dc_flush));

    // R5: run power-down bit frozen while the guard is closed
    a_r5_run_locked: assert property (@(posedge clk) disable iff (rst)
        !run_wr_ok |=> $stable(cur_q.run_off));

    // R2: unselected lanes hold
    a_r2_lane_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_be[0]) |=> $stable(cur_q.wait_st));

endmodule

// File: rtl/flash_pd_sel.sv
module flash_pd_sel (
    input  logic clk,
    input  logic rst,
    input  logic sleep_mode,
    input  logic pe_busy,
    input  logic sleep_off,
    input  logic run_off,
    input  logic rd_req,
    output logic flash_pd,
    output logic rd_fwd,
    output logic acc_err
);

    logic want_pd;

    assign want_pd  = sleep_mode ? sleep_off : run_off;
    assign flash_pd = want_pd & ~pe_busy;
    assign rd_fwd   = rd_req & ~run_off;
    assign acc_err  = rd_req & run_off;

    // R9: never power down during program/erase
    a_r9_busy_no_pd: assert property (@(posedge clk) disable iff (rst)
        pe_busy |-> !flash_pd);

    // R10: a read is either forwarded or flagged, never both
    a_r10_fwd_xor_err: assert property (@(posedge clk) disable iff (rst)
        !(rd_fwd && acc_err));

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import flash_ctl_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          CTRL_OFS = 0,
    parameter int          KEY_OFS  = 4,
    parameter logic [31:0] KEY_A    = 32'h0415_2637,
    parameter logic [31:0] KEY_B    = 32'hFAFB_FCFD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sleep_mode,
    input  logic              pe_busy,
    input  logic              rd_req,
    output logic              flash_pd,
    output logic              rd_fwd,
    output logic              acc_err,
    output logic [3:0]        wait_states,
    output logic              prefetch_en,
    output logic              icache_en,
    output logic              dcache_en,
    output logic              icache_rst,
    output logic              dcache_rst,
    output logic              dbg_en
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);

    logic        hit_ctrl, hit_key;
    logic        ctl_wr, key_wr, ctl_rd;
    logic        run_wr_ok;
    ctl_fields_t fields;
    logic [31:0] ctl_word;

    assign hit_ctrl = bus_sel && (bus_addr == A_CTRL);
    assign hit_key  = bus_sel && (bus_addr == A_KEY);
    assign ctl_wr   = hit_ctrl && bus_wr;
    assign ctl_rd   = hit_ctrl && !bus_wr;
    assign key_wr   = hit_key && bus_wr;

    flash_key_gate #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_be   (bus_be),
        .key_data (bus_wdata),
        .consume  (ctl_wr && bus_be[1]),
        .run_wr_ok(run_wr_ok)
    );

    flash_ctl_fields u_fields (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_be   (bus_be),
        .ctl_wdata(bus_wdata),
        .run_wr_ok(run_wr_ok),
        .fields   (fields),
        .ctl_word (ctl_word)
    );

    flash_pd_sel u_pd (
        .clk       (clk),
        .rst       (rst),
        .sleep_mode(sleep_mode),
        .pe_busy   (pe_busy),
        .sleep_off (fields.sleep_off),
        .run_off   (fields.run_off),
        .rd_req    (rd_req),
        .flash_pd  (flash_pd),
        .rd_fwd    (rd_fwd),
        .acc_err   (acc_err)
    );

    assign bus_rdata   = ctl_rd ? ctl_word : '0;
    assign wait_states = fields.wait_st;
    assign prefetch_en = fields.pf_on;
    assign icache_en   = fields.ic_on;
    assign dcache_en   = fields.dc_on;
    assign icache_rst  = fields.ic_flush;
    assign dcache_rst  = fields.dc_flush;
    assign dbg_en      = fields.dbg_on;

    // R3: reserved bits never appear on the read bus
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~FIELD_MASK) == '0);

    // R10: no forwarding while run power-down is selected
    a_r10_block_fwd: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ctl_word[POS_RUN]) |-> (acc_err && !rd_fwd));

endmodule

// File: tb/sim_flash_ctl_reg.sv
module sim_flash_ctl_reg;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] K1   = 32'h0415_2637;
    localparam logic [31:0] K2   = 32'hFAFB_FCFD;
    localparam logic [31:0] MASK = 32'h0004_7F0F;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [3:0]  bus_addr = 0, bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        sleep_mode = 0, pe_busy = 0, rd_req = 0;
    logic        flash_pd, rd_fwd, acc_err;
    logic [3:0]  wait_states;
    logic        prefetch_en, icache_en, dcache_en, icache_rst, dcache_rst, dbg_en;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_reg;
    int          m_key;   // 0 idle, 1 half, 2 open, 3 dead

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ctl_reg u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sleep_mode(sleep_mode), .pe_busy(pe_busy),
        .rd_req(rd_req), .flash_pd(flash_pd), .rd_fwd(rd_fwd), .acc_err(acc_err),
        .wait_states(wait_states), .prefetch_en(prefetch_en), .icache_en(icache_en),
        .dcache_en(dcache_en), .icache_rst(icache_rst), .dcache_rst(dcache_rst),
        .dbg_en(dbg_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_reg = 32'h0000_0600;
        m_key = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] n;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        if (a == 4'h0) begin
            n = m_reg;
            for (int i = 0; i < 4; i++) if (be[i]) n[8*i +: 8] = d[8*i +: 8];
            n = n & MASK;
            if (m_reg[10]) n[12] = m_reg[12];
            if (m_key != 2) n[13] = m_reg[13];
            if (m_key == 2 && be[1]) m_key = 0;
            m_reg = n;
        end else if (a == 4'h4) begin
            if (be != 4'hF)                 m_key = 3;
            else if (m_key == 0)            m_key = (d == K1) ? 1 : 3;
            else if (m_key == 1)            m_key = (d == K2) ? 2 : 3;
            else                            m_key = 3;
        end
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic unlock();
        wr(4'h4, 4'hF, K1);
        wr(4'h4, 4'hF, K2);
    endtask

    task automatic pd_chk(input string req, input logic sl, input logic busy, input logic exp);
        @(negedge clk);
        sleep_mode = sl; pe_busy = busy;
        #1 chk(req, {31'b0, flash_pd}, {31'b0, exp});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
        pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;

        do_reset();
        // R1 reset state
        rd_chk("R1", 4'h0, 32'h0000_0600);
        #1 chk("R1 pd", {31'b0, flash_pd}, 32'h0);
        chk("R1 cache", {30'b0, icache_en, dcache_en}, 32'h3);

        // R3 key offset and idle bus read zero
        rd_chk("R3 key", 4'h4, 32'h0);
        @(negedge clk); #1 chk("R3 idle", bus_rdata, 32'h0);

        // R2 byte-lane sweep (guard locked, R4 gating via model)
        for (int b = 0; b < 16; b++) begin
            for (int p = 0; p < 4; p++) begin
                wr(4'h0, 4'(b), pats[p]);
                rd_chk("R2", 4'h0, m_reg);
            end
        end

        // R4 data-cache flush guard
        wr(4'h0, 4'hF, 32'h0);
        rd_chk("R4 clear", 4'h0, 32'h0);
        wr(4'h0, 4'hF, 32'h1000);
        rd_chk("R4 off-set", 4'h0, 32'h1000);
        wr(4'h0, 4'hF, 32'h0400);
        rd_chk("R4 enable", 4'h0, 32'h0400);
        wr(4'h0, 4'hF, 32'h1400);
        rd_chk("R4 on-blocked", 4'h0, 32'h0400);
        wr(4'h0, 4'hF, 32'h0000);
        rd_chk("R4 disable", 4'h0, 32'h0000);
        wr(4'h0, 4'h2, 32'h0000_1400);
        rd_chk("R4 off-byte", 4'h0, 32'h1400);
        wr(4'h0, 4'hF, 32'h0000);
        rd_chk("R4 on-keeps", 4'h0, 32'h1000);
        wr(4'h0, 4'hF, 32'h0000);
        rd_chk("R4 off-clear", 4'h0, 32'h0000);

        // R5 locked write ignored, then unlock
        wr(4'h0, 4'hF, 32'h2000);
        rd_chk("R5 locked", 4'h0, 32'h0);
        unlock();
        wr(4'h0, 4'hF, 32'h2000);
        rd_chk("R5 open", 4'h0, 32'h2000);
        // R6 consumed
        wr(4'h0, 4'hF, 32'h0);
        rd_chk("R6 consumed", 4'h0, 32'h2000);

        // R8/R9 run mode power-down with busy
        pd_chk("R8 run", 0, 0, 1);
        pd_chk("R9 busy", 0, 1, 0);
        pd_chk("R9 release", 0, 0, 1);
        // R10 reads blocked
        @(negedge clk); rd_req = 1;
        #1 chk("R10 blocked", {30'b0, rd_fwd, acc_err}, 32'h1);
        rd_req = 0;
        unlock();
        wr(4'h0, 4'h2, 32'h0);
        rd_chk("R6 relock clear", 4'h0, 32'h0);
        @(negedge clk); rd_req = 1;
        #1 chk("R10 fwd", {30'b0, rd_fwd, acc_err}, 32'h2);
        rd_req = 0;

        // R8 sweep of mode x selections, R9 busy on each
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < 2; s++) begin
                unlock();
                wr(4'h0, 4'h2, {16'b0, 1'b0, 1'(s), 1'(r), 13'b0});
                rd_chk("R8 setup", 4'h0, m_reg);
                for (int m = 0; m < 2; m++) begin
                    pd_chk("R8 sel", 1'(m), 0, (m == 1) ? 1'(s) : 1'(r));
                    pd_chk("R9 mask", 1'(m), 1, 0);
                end
            end
        end
        pd_chk("R8 idle", 0, 0, 1);

        // R7 wrong key locks out
        unlock();
        wr(4'h0, 4'h2, 32'h0);
        rd_chk("R7 pre", 4'h0, 32'h0);
        wr(4'h4, 4'hF, K1);
        wr(4'h4, 4'hF, 32'h1234_5678);
        unlock();
        wr(4'h0, 4'hF, 32'h2000);
        rd_chk("R7 wrong", 4'h0, 32'h0);

        // R7 half-word key locks out
        do_reset();
        rd_chk("R1 again", 4'h0, 32'h0000_0600);
        wr(4'h4, 4'h3, K1);
        unlock();
        wr(4'h0, 4'hF, 32'h2600);
        rd_chk("R7 partial", 4'h0, 32'h0600);

        // R7 key write while open locks out
        do_reset();
        unlock();
        wr(4'h4, 4'hF, K1);
        wr(4'h0, 4'hF, 32'h2600);
        rd_chk("R7 reopen", 4'h0, 32'h0600);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule